// File: doc/BRIEF.md
# Drift-Corrected Nanosecond Time Counter

This block keeps a 64-bit time-of-day value in nanoseconds for precision time stamping. The value is offered on a live output bus. Each clock cycle the counter advances by a fixed nominal increment. To trim the effective rate, a programmable correction adds or removes a small whole number of nanoseconds once every correction interval. The interval is set in 16 ns quanta, which avoids the need for a fractional accumulator.

Software controls the block through a simple single-cycle register port. It can pause the counter, load both 32-bit halves, and resume counting. It can hold the drift logic in reset while it writes a new 32-bit drift word, then release it. It reads the time as two 32-bit words, and reading the low word freezes a copy of the high word so that the pair belongs to the same instant. The register port carries only control and status, so it has no valid/ready handshake: a write takes effect on the clock edge that samples `reg_wr`, and read data appears on `reg_rdata` one cycle after `reg_rd`.

Register addresses are 0 control, 1 drift hold, 2 drift word, 3 load low, 4 load high, 5 time low and 6 time high. Any other address reads as zero.

Top module: `ptp_drift_clock`

## Requirements
- R1: After reset the counter holds 0 and runs, and the drift word and drift hold are 0. A control read then returns 4.
- R2: On each running cycle with no correction due, the time advances by exactly NOM_INC (default 8) ns.
- R3: The drift word is laid out as period in bits [27:0], step in bits [30:28] and direction in bit 31. The drift timer gains NOM_INC ns on every running, unheld cycle. The correction is applied on the cycle where the accumulated total reaches period×16+8 ns, and any excess carries over. With NOM_INC = 8 this is every 2×period+1 cycles.
- R4: When bit 31 of the drift word is 1, the correcting cycle advances the time by NOM_INC+step. When it is 0, that cycle advances the time by NOM_INC−step.
- R5: Writing 2 to the control register pauses the counter and writing 4 resumes it. Any other value is ignored. A control read returns 2 when paused and 4 when running.
- R6: Writes to load low and load high replace that half of the time only while the counter is paused. While it runs they are ignored.
- R7: While drift hold (bit 0 of register 1) is 1, the drift timer is cleared and no correction is applied. Register 1 reads back the hold bit.
- R8: A read of time low returns the low 32 bits and copies the high 32 bits into a shadow. A read of time high returns that shadow. Read data is valid the cycle after `reg_rd`.
- R9: A step of 0, which covers a drift word of 0 and a period of 0x0FFFFFFF with step 0, applies no correction.
- R10: While paused, the time and the drift timer do not change except through loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one nominal tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| time_now | output | 64 | Live time in nanoseconds |

## Verification
A correction can be due on the same edge that a pause command is captured. It can also be due on the same edge that a time-low read latches the shadow. The sweep over period, step and direction picks run lengths so that some pauses land exactly on a correcting edge. The expected time, computed from the correction count, shows whether that last correction was applied. A separate run places a low-word read just before a carry into the high word, and the shadowed high word must match the value from before the carry.

// File: rtl/ptpdc_pkg.sv
package ptpdc_pkg;
  localparam int PERIOD_W = 28;
  localparam int STEP_W   = 3;

  typedef struct packed {
    logic                add;
    logic [STEP_W-1:0]   step;
    logic [PERIOD_W-1:0] period;
  } drift_cfg_t;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_DRST = 3'd1,
    A_DCFG = 3'd2,
    A_LDLO = 3'd3,
    A_LDHI = 3'd4,
    A_TLO  = 3'd5,
    A_THI  = 3'd6
  } reg_addr_e;

  localparam logic [31:0] CMD_PAUSE  = 32'd2;
  localparam logic [31:0] CMD_RESUME = 32'd4;
endpackage

// File: rtl/ptpdc_drift_timer.sv
module ptpdc_drift_timer
  import ptpdc_pkg::*;
#(
  parameter int NOM_INC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       hold,
  input  drift_cfg_t cfg,
  output logic       fire
);
  localparam int ACC_W = PERIOD_W + 5;

  logic [ACC_W-1:0] elapsed_q, next_acc, interval, residual;

  always_comb begin
    interval = ACC_W'({cfg.period, 4'b0000}) + ACC_W'(8);
    next_acc = elapsed_q + ACC_W'(NOM_INC);
    residual = next_acc - interval;
    fire     = run && !hold && (cfg.step != '0) && (next_acc >= interval);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          elapsed_q <= '0;
    else if (hold || cfg.step == '0)     elapsed_q <= '0;
    else if (run && fire)                elapsed_q <= (residual >= interval) ? '0 : residual;
    else if (run)                        elapsed_q <= next_acc;
  end

  // R7
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> elapsed_q == '0);

  // R3
  carry_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !$changed(cfg)) |=> elapsed_q < $past(interval));

  // R10
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !hold && cfg.step != '0) |=> elapsed_q == $past(elapsed_q));
endmodule

// File: rtl/ptpdc_time_counter.sv
module ptpdc_time_counter
  import ptpdc_pkg::*;
#(
  parameter int NOM_INC = 8,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                fire,
  input  drift_cfg_t          cfg,
  input  logic                load_lo,
  input  logic                load_hi,
  input  logic [DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0] time_q
);
  localparam int TIME_W = 2 * DATA_W;

  logic [TIME_W-1:0] inc;

  always_comb begin
    inc = TIME_W'(NOM_INC);
    if (fire) inc = cfg.add ? inc + TIME_W'(cfg.step) : inc - TIME_W'(cfg.step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= '0;
    else if (run) time_q <= time_q + inc;
    else begin
      if (load_lo) time_q[DATA_W-1:0]      <= wdata;
      if (load_hi) time_q[TIME_W-1:DATA_W] <= wdata;
    end
  end
endmodule

// File: rtl/ptpdc_regs.sv
module ptpdc_regs
  import ptpdc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [2:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic [2*DATA_W-1:0] time_q,
  output logic                run,
  output logic                hold,
  output drift_cfg_t          cfg,
  output logic                load_lo,
  output logic                load_hi,
  output logic [DATA_W-1:0]   reg_rdata
);
  localparam int TIME_W = 2 * DATA_W;

  logic              paused_q;
  logic [DATA_W-1:0] shadow_q;
  reg_addr_e         addr;

  assign addr    = reg_addr_e'(reg_addr);
  assign run     = !paused_q;
  assign load_lo = reg_wr && addr == A_LDLO;
  assign load_hi = reg_wr && addr == A_LDHI;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paused_q <= 1'b0;
      hold     <= 1'b0;
      cfg      <= '0;
    end else if (reg_wr) begin
      case (addr)
        A_CTRL: begin
          if (reg_wdata == CMD_PAUSE)       paused_q <= 1'b1;
          else if (reg_wdata == CMD_RESUME) paused_q <= 1'b0;
        end
        A_DRST:  hold <= reg_wdata[0];
        A_DCFG:  cfg  <= drift_cfg_t'(reg_wdata);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      shadow_q  <= '0;
    end else if (reg_rd) begin
      case (addr)
        A_CTRL:  reg_rdata <= paused_q ? CMD_PAUSE : CMD_RESUME;
        A_DRST:  reg_rdata <= DATA_W'(hold);
        A_DCFG:  reg_rdata <= cfg;
        A_TLO: begin
          reg_rdata <= time_q[DATA_W-1:0];
          shadow_q  <= time_q[TIME_W-1:DATA_W];
        end
        A_THI:   reg_rdata <= shadow_q;
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R5
  pause_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'(A_CTRL) && reg_wdata == CMD_PAUSE) |=> !run);

  // R5
  other_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'(A_CTRL) && reg_wdata != CMD_PAUSE && reg_wdata != CMD_RESUME)
      |=> $stable(run));

  // R8
  shadow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'(A_TLO)) |=> shadow_q == $past(time_q[TIME_W-1:DATA_W]));
endmodule

// File: rtl/ptp_drift_clock.sv
module ptp_drift_clock
  import ptpdc_pkg::*;
#(
  parameter int NOM_INC = 8,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [2:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [2*DATA_W-1:0] time_now
);
  localparam int TIME_W = 2 * DATA_W;

  logic              run, hold, fire, load_lo, load_hi;
  drift_cfg_t        cfg;
  logic [TIME_W-1:0] time_q;

  ptpdc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .time_q(time_q),
    .run(run), .hold(hold), .cfg(cfg), .load_lo(load_lo),
    .load_hi(load_hi), .reg_rdata(reg_rdata)
  );

  ptpdc_drift_timer #(.NOM_INC(NOM_INC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .hold(hold), .cfg(cfg), .fire(fire)
  );

  ptpdc_time_counter #(.NOM_INC(NOM_INC), .DATA_W(DATA_W)) u_count (
    .clk(clk), .rst_n(rst_n), .run(run), .fire(fire), .cfg(cfg),
    .load_lo(load_lo), .load_hi(load_hi), .wdata(reg_wdata), .time_q(time_q)
  );

  assign time_now = time_q;

  // R2
  nominal_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fire) |=> time_q == $past(time_q) + TIME_W'(NOM_INC));

  // R4
  add_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fire && cfg.add) |=>
      time_q == $past(time_q) + TIME_W'(NOM_INC) + TIME_W'($past(cfg.step)));

  // R4
  sub_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fire && !cfg.add) |=>
      time_q == $past(time_q) + TIME_W'(NOM_INC) - TIME_W'($past(cfg.step)));

  // R10
  paused_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_lo && !load_hi) |=> $stable(time_q));

  // R7
  hold_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold) && hold |-> !fire);
endmodule

// File: tb/test_ptp_drift_clock.sv
module test_ptp_drift_clock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] time_now;

  int checks = 0, errors = 0;
  bit done = 0;

  ptp_drift_clock i_ptp_drift_clock (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .time_now(time_now)
  );

  always #10 clk = ~clk;

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  // resume, then pause so that exactly n counting edges occur
  task automatic run_ticks(int n);
    wr(3'd0, 32'd4);
    repeat (n - 1) @(negedge clk);
    wr(3'd0, 32'd2);
  endtask

  task automatic read_time(output logic [63:0] t);
    logic [31:0] lo, hi;
    rd(3'd5, lo);
    rd(3'd6, hi);
    t = {hi, lo};
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t, x;
    repeat (3) @(negedge clk);
    check("R1 time after reset", time_now, 64'd0);
    rst_n = 1'b1;
    rd(3'd0, d); check("R1 ctrl reads running", 64'(d), 64'd4);
    rd(3'd2, d); check("R1 drift word zero", 64'(d), 64'd0);
    rd(3'd1, d); check("R1 drift hold zero", 64'(d), 64'd0);

    // R2/R9 with drift word 0: pure nominal advance
    wr(3'd0, 32'd2);
    wr(3'd3, 32'h0000_1000); wr(3'd4, 32'h0000_0002);
    run_ticks(25);
    read_time(t);
    check("R2 nominal advance", t, 64'h2_0000_1000 + 64'd200);

    // R9: period 0x0FFFFFFF with step 0
    wr(3'd2, 32'h0FFF_FFFF);
    wr(3'd3, 32'd0); wr(3'd4, 32'd0);
    run_ticks(40);
    read_time(t);
    check("R9 max period step zero", t, 64'd320);

    // R5: unknown command ignored, still paused and frozen (R10)
    wr(3'd0, 32'd3);
    rd(3'd0, d); check("R5 ctrl ignores 3", 64'(d), 64'd2);
    repeat (5) @(negedge clk);
    read_time(t);
    check("R10 frozen while paused", t, 64'd320);

    // sweep: period 0..3, step 0..7, both directions
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 8; s++)
        for (int dr = 0; dr < 2; dr++) begin
          int idx, tt, n, fires;
          longint unsigned base, exp;
          idx = p * 16 + s * 2 + dr;
          tt = 2 * p + 1;
          n = 3 * tt + (s % tt) + 1;
          fires = (s == 0) ? 0 : n / tt;
          base = {32'(idx), 32'hFFFF_FF80 + 32'(idx * 4)};
          exp = base + longint'(n * 8);
          if (dr == 1) exp = exp + longint'(fires * s);
          else         exp = exp - longint'(fires * s);
          wr(3'd1, 32'd1);
          rd(3'd1, d); check("R7 hold reads back", 64'(d), 64'd1);
          wr(3'd2, {1'(dr), 3'(s), 28'(p)});
          wr(3'd3, base[31:0]); wr(3'd4, base[63:32]);
          wr(3'd1, 32'd0);
          run_ticks(n);
          read_time(t);
          check("R3 R4 drift sweep", t, exp);
        end

    // R7: hold set, step 7 add, no correction
    wr(3'd1, 32'd1);
    wr(3'd2, {1'b1, 3'd7, 28'd0});
    wr(3'd3, 32'd100); wr(3'd4, 32'd0);
    run_ticks(9);
    read_time(t);
    check("R7 hold suppresses correction", t, 64'd172);

    // R6: load ignored while running (two counting edges)
    x = 64'd172;
    wr(3'd0, 32'd4);
    wr(3'd3, 32'h0000_0123);
    wr(3'd0, 32'd2);
    read_time(t);
    check("R6 load ignored while running", t, x + 64'd16);

    // R8: coherent read across a carry
    wr(3'd3, 32'hFFFF_FFF8); wr(3'd4, 32'd5);
    wr(3'd0, 32'd4);
    rd(3'd5, d); check("R8 low word", 64'(d), 64'hFFFF_FFF8);
    rd(3'd6, d); check("R8 shadowed high", 64'(d), 64'd5);
    wr(3'd0, 32'd2);
    rd(3'd0, d); check("R5 ctrl reads paused", 64'(d), 64'd2);
    read_time(t);
    check("R8 live after carry", t, 64'h5_FFFF_FFF8 + 64'd24);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule